// File: doc/BRIEF.md
# Shared-Bus Memory-to-Device Copy Engine

This block copies a run of words from memory to a device write port without the CPU touching the data. The CPU writes a source address and a word count through a four-entry register interface, then writes the start bit. From then on the engine fetches each word over the memory bus that the CPU also uses, holds it, and hands it to the device when the device is ready. When the last word has been accepted, the engine sets a done flag. If interrupts are enabled it raises a level interrupt, which the CPU clears by writing 1 to the done bit.

The memory bus has a single port. A built-in arbiter decides who owns the bus in each cycle. A control bit chooses whether the engine or the CPU wins when both ask in the same cycle. The side that loses sees no grant and must keep its request unchanged until it is granted. The memory returns read data one cycle after a granted read. The engine keeps at most one word in flight, so a word it has read stays on the device port until the device takes it.

Top module: `dma_copy_ctrl`

## Requirements
- R1: Register offsets are 0 = source address, 1 = word count, 2 = control and 3 = status. Control bit 1 selects CPU priority when 1. Control bit 2 enables the interrupt. Control bit 0 is a start strobe and always reads 0. Status bit 0 is busy and status bit 1 is done. All registers read 0 after reset, and a written address, count or control value reads back.
- R2: Writing 1 to control bit 0 while idle starts a transfer, and busy reads 1 from the next cycle. The words at memory[src], memory[src+1] and so on reach the device port in that order, one for each cycle in which dev_valid and dev_ready are both high.
- R3: The engine uses the bus only while busy, and only for reads (mem_we = 0). The address of each read is src plus the number of words already delivered.
- R4: At most one requester is granted in a cycle. When only one side requests, that side is granted in the same cycle. When both request, the engine wins if control bit 1 is 0 and the CPU wins if it is 1. The bus carries the address, write enable and data of the granted side.
- R5: A stalled engine request stays asserted with an unchanged address until it is granted.
- R6: While dev_valid is high and dev_ready is low, dev_valid stays high and dev_data does not change in the next cycle.
- R7: In the cycle after the device accepts the last word, busy reads 0 and done reads 1. No further words are offered.
- R8: irq is high exactly when done and the interrupt enable are both 1. Writing 1 to status bit 1 clears done and irq. Writing 0 to that bit leaves done unchanged.
- R9: A start write while busy is ignored. The running transfer continues from its original source and count, and a new source address written meanwhile is used only by the next start.
- R10: A start with a word count of 0 sets done in the next cycle, never sets busy, and makes no bus access.
- R11: A start with a non-zero count clears a done flag left over from an earlier transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset for read and write |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Read data of the register at reg_addr (combinational) |
| cpu_req | input | 1 | CPU memory request |
| cpu_we | input | 1 | CPU request is a write |
| cpu_addr | input | AW | CPU memory address |
| cpu_wdata | input | DW | CPU write data |
| cpu_gnt | output | 1 | CPU owns the bus this cycle |
| mem_req | output | 1 | Bus access this cycle |
| mem_we | output | 1 | Bus access is a write |
| mem_addr | output | AW | Bus address |
| mem_wdata | output | DW | Bus write data |
| mem_rdata | input | DW | Read data, valid the cycle after a granted read |
| dev_valid | output | 1 | A word is offered to the device |
| dev_data | output | DW | Offered word |
| dev_ready | input | 1 | Device accepts the offered word this cycle |
| irq | output | 1 | Level completion interrupt |

## Verification
The bench sweeps word counts from zero upward against every combination of bus priority, device-ready pattern and CPU traffic pattern. In every cycle it checks who owns the bus, which address the engine reads, and the data reaching the device. A wrong priority polarity would grant the CPU while the engine holds priority, and an off-by-one count would deliver one word too many or too few, or set done early. A zero count that is not special-cased would start a run through the whole address range. A start that is honoured while busy would restart from the newly written source and send the wrong words. A clear of done that is not write-1 would drop the interrupt when 0 is written.

// File: rtl/dma_pkg.sv
package dma_pkg;
   localparam logic [1:0] REG_SRC    = 2'd0;
   localparam logic [1:0] REG_LEN    = 2'd1;
   localparam logic [1:0] REG_CTRL   = 2'd2;
   localparam logic [1:0] REG_STATUS = 2'd3;

   localparam int CTRL_START = 0;
   localparam int CTRL_PRIO  = 1;
   localparam int CTRL_IE    = 2;
   localparam int ST_BUSY    = 0;
   localparam int ST_DONE    = 1;

   typedef enum logic [1:0] {
      MV_IDLE  = 2'd0,
      MV_FETCH = 2'd1,
      MV_WAIT  = 2'd2,
      MV_HOLD  = 2'd3
   } mv_state_t;
endpackage

// File: rtl/dma_cfg_regs.sv
module dma_cfg_regs
   import dma_pkg::*;
#(
   parameter int DW = 16,
   parameter int AW = 8,
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr,
   input  logic [1:0]    addr,
   input  logic [DW-1:0] wdata,
   input  logic          busy,
   input  logic          fin,
   output logic [DW-1:0] rdata,
   output logic [AW-1:0] src_q,
   output logic [CW-1:0] len_q,
   output logic          prio_cpu,
   output logic          done,
   output logic          go,
   output logic          irq
);
   logic irq_en;
   logic start_req;
   logic zero_len;
   logic clr_req;
   logic unused_wdata_bits;

   assign unused_wdata_bits = ^wdata;
   assign zero_len  = (len_q == '0);
   assign start_req = wr && (addr == REG_CTRL) && wdata[CTRL_START] && !busy;
   assign go        = start_req && !zero_len;
   assign clr_req   = wr && (addr == REG_STATUS) && wdata[ST_DONE];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_q    <= '0;
         len_q    <= '0;
         prio_cpu <= 1'b0;
         irq_en   <= 1'b0;
      end else if (wr) begin
         case (addr)
            REG_SRC:  src_q <= wdata[AW-1:0];
            REG_LEN:  len_q <= wdata[CW-1:0];
            REG_CTRL: begin
               prio_cpu <= wdata[CTRL_PRIO];
               irq_en   <= wdata[CTRL_IE];
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      done <= 1'b0;
      else if (fin)                    done <= 1'b1;
      else if (start_req && zero_len)  done <= 1'b1;
      else if (go)                     done <= 1'b0;
      else if (clr_req)                done <= 1'b0;
   end

   assign irq = done & irq_en;

   always_comb begin
      rdata = '0;
      case (addr)
         REG_SRC:  rdata[AW-1:0] = src_q;
         REG_LEN:  rdata[CW-1:0] = len_q;
         REG_CTRL: begin
            rdata[CTRL_PRIO] = prio_cpu;
            rdata[CTRL_IE]   = irq_en;
         end
         default: begin
            rdata[ST_BUSY] = busy;
            rdata[ST_DONE] = done;
         end
      endcase
   end
endmodule

// File: rtl/dma_bus_arb.sv
module dma_bus_arb #(
   parameter int DW = 16,
   parameter int AW = 8
) (
   input  logic          prio_cpu,
   input  logic          cpu_req,
   input  logic          cpu_we,
   input  logic [AW-1:0] cpu_addr,
   input  logic [DW-1:0] cpu_wdata,
   input  logic          dma_req,
   input  logic [AW-1:0] dma_addr,
   output logic          cpu_gnt,
   output logic          dma_gnt,
   output logic          mem_req,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata
);
   logic contend;

   assign contend = cpu_req && dma_req;

   always_comb begin
      if (contend) begin
         cpu_gnt = prio_cpu;
         dma_gnt = !prio_cpu;
      end else begin
         cpu_gnt = cpu_req;
         dma_gnt = dma_req;
      end
   end

   assign mem_req   = cpu_gnt || dma_gnt;
   assign mem_we    = cpu_gnt && cpu_we;
   assign mem_addr  = cpu_gnt ? cpu_addr : dma_addr;
   assign mem_wdata = cpu_gnt ? cpu_wdata : '0;
endmodule

// File: rtl/dma_word_mover.sv
module dma_word_mover
   import dma_pkg::*;
#(
   parameter int DW = 16,
   parameter int AW = 8,
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          go,
   input  logic [AW-1:0] src,
   input  logic [CW-1:0] len,
   input  logic          dma_gnt,
   input  logic [DW-1:0] mem_rdata,
   input  logic          dev_ready,
   output logic          dma_req,
   output logic [AW-1:0] dma_addr,
   output logic          dev_valid,
   output logic [DW-1:0] dev_data,
   output logic          busy,
   output logic          fin
);
   localparam logic [CW-1:0] ONE = CW'(1);

   mv_state_t     st;
   logic [AW-1:0] ptr;
   logic [CW-1:0] left;
   logic [DW-1:0] hold;
   logic          last;
   logic          take;

   assign dma_req   = (st == MV_FETCH);
   assign dma_addr  = ptr;
   assign dev_valid = (st == MV_HOLD);
   assign dev_data  = hold;
   assign busy      = (st != MV_IDLE);
   assign last      = (left == ONE);
   assign take      = dev_valid && dev_ready;
   assign fin       = take && last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= MV_IDLE;
         ptr  <= '0;
         left <= '0;
         hold <= '0;
      end else begin
         case (st)
            MV_IDLE: if (go) begin
               ptr  <= src;
               left <= len;
               st   <= MV_FETCH;
            end
            MV_FETCH: if (dma_gnt) st <= MV_WAIT;
            MV_WAIT: begin
               hold <= mem_rdata;
               st   <= MV_HOLD;
            end
            default: if (take) begin
               ptr  <= ptr + ONE[0];
               left <= left - ONE;
               st   <= last ? MV_IDLE : MV_FETCH;
            end
         endcase
      end
   end
endmodule

// File: rtl/dma_copy_ctrl.sv
module dma_copy_ctrl #(
   parameter int DW = 16,
   parameter int AW = 8,
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          reg_wr,
   input  logic [1:0]    reg_addr,
   input  logic [DW-1:0] reg_wdata,
   output logic [DW-1:0] reg_rdata,
   input  logic          cpu_req,
   input  logic          cpu_we,
   input  logic [AW-1:0] cpu_addr,
   input  logic [DW-1:0] cpu_wdata,
   output logic          cpu_gnt,
   output logic          mem_req,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata,
   input  logic [DW-1:0] mem_rdata,
   output logic          dev_valid,
   output logic [DW-1:0] dev_data,
   input  logic          dev_ready,
   output logic          irq
);
   if (AW > DW) begin : g_bad_aw
      $error("address width must fit in a register word");
   end
   if (CW > DW) begin : g_bad_cw
      $error("count width must fit in a register word");
   end
   if (DW < 3) begin : g_bad_dw
      $error("register word too narrow for control bits");
   end

   logic          busy;
   logic          done;
   logic          fin;
   logic          go;
   logic          prio_cpu;
   logic [AW-1:0] src_q;
   logic [CW-1:0] len_q;
   logic          dma_req;
   logic          dma_gnt;
   logic [AW-1:0] dma_addr;

   dma_cfg_regs #(.DW(DW), .AW(AW), .CW(CW)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (reg_wr),
      .addr     (reg_addr),
      .wdata    (reg_wdata),
      .busy     (busy),
      .fin      (fin),
      .rdata    (reg_rdata),
      .src_q    (src_q),
      .len_q    (len_q),
      .prio_cpu (prio_cpu),
      .done     (done),
      .go       (go),
      .irq      (irq)
   );

   dma_word_mover #(.DW(DW), .AW(AW), .CW(CW)) u_mover (
      .clk       (clk),
      .rst_n     (rst_n),
      .go        (go),
      .src       (src_q),
      .len       (len_q),
      .dma_gnt   (dma_gnt),
      .mem_rdata (mem_rdata),
      .dev_ready (dev_ready),
      .dma_req   (dma_req),
      .dma_addr  (dma_addr),
      .dev_valid (dev_valid),
      .dev_data  (dev_data),
      .busy      (busy),
      .fin       (fin)
   );

   dma_bus_arb #(.DW(DW), .AW(AW)) u_arb (
      .prio_cpu  (prio_cpu),
      .cpu_req   (cpu_req),
      .cpu_we    (cpu_we),
      .cpu_addr  (cpu_addr),
      .cpu_wdata (cpu_wdata),
      .dma_req   (dma_req),
      .dma_addr  (dma_addr),
      .cpu_gnt   (cpu_gnt),
      .dma_gnt   (dma_gnt),
      .mem_req   (mem_req),
      .mem_we    (mem_we),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata)
   );
endmodule

// File: rtl/dma_copy_chk.sv
module dma_copy_chk #(
   parameter int DW = 16,
   parameter int AW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cpu_req,
   input logic          cpu_gnt,
   input logic          dma_req,
   input logic          dma_gnt,
   input logic [AW-1:0] dma_addr,
   input logic          prio_cpu,
   input logic          busy,
   input logic          done,
   input logic          irq,
   input logic          mem_we,
   input logic          dev_valid,
   input logic          dev_ready,
   input logic [DW-1:0] dev_data
);
   assert_one_grant_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({cpu_gnt, dma_gnt}));

   assert_cpu_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_req && prio_cpu |-> cpu_gnt);

   assert_dma_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
      dma_req && !prio_cpu |-> dma_gnt);

   assert_dma_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
      dma_req && !dma_gnt |=> dma_req && $stable(dma_addr));

   assert_dev_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      dev_valid && !dev_ready |=> dev_valid && $stable(dev_data));

   assert_idle_no_bus_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !dma_req);

   assert_dma_reads_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
      dma_gnt |-> !mem_we);

   assert_done_on_finish_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);

   assert_irq_needs_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> done);
endmodule

bind dma_copy_ctrl dma_copy_chk #(.DW(DW), .AW(AW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cpu_req   (cpu_req),
   .cpu_gnt   (cpu_gnt),
   .dma_req   (dma_req),
   .dma_gnt   (dma_gnt),
   .dma_addr  (dma_addr),
   .prio_cpu  (prio_cpu),
   .busy      (busy),
   .done      (done),
   .irq       (irq),
   .mem_we    (mem_we),
   .dev_valid (dev_valid),
   .dev_ready (dev_ready),
   .dev_data  (dev_data)
);

// File: tb/tb_dma_copy_ctrl.sv
`timescale 1ns/1ps
module tb_dma_copy_ctrl;
   localparam int DW = 16;
   localparam int AW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_wr = 1'b0;
   logic [1:0]    reg_addr = 2'd3;
   logic [DW-1:0] reg_wdata = '0;
   logic [DW-1:0] reg_rdata;
   logic          cpu_req = 1'b0;
   logic          cpu_we = 1'b0;
   logic [AW-1:0] cpu_addr = '0;
   logic [DW-1:0] cpu_wdata = '0;
   logic          cpu_gnt;
   logic          mem_req;
   logic          mem_we;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_wdata;
   logic [DW-1:0] mem_rdata = '0;
   logic          dev_valid;
   logic [DW-1:0] dev_data;
   logic          dev_ready = 1'b0;
   logic          irq;

   always #2 clk = ~clk;

   dma_copy_ctrl dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cpu_req(cpu_req),
      .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
      .cpu_gnt(cpu_gnt), .mem_req(mem_req), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .dev_valid(dev_valid), .dev_data(dev_data), .dev_ready(dev_ready),
      .irq(irq)
   );

   function automatic logic [DW-1:0] pat(input int a);
      return DW'(a * 37 + 5);
   endfunction

   logic [DW-1:0] mem [256];
   initial for (int i = 0; i < 256; i++) mem[i] = pat(i);
   always @(posedge clk) begin
      if (mem_req) begin
         if (mem_we) mem[mem_addr] <= mem_wdata;
         else        mem_rdata     <= mem[mem_addr];
      end
   end

   int n_cmp = 0;
   int n_bad = 0;
   int cyc = 0;
   bit          pend_wr = 1'b0;
   logic [1:0]  pend_addr = 2'd3;
   logic [DW-1:0] pend_data = '0;
   int cpu_mode = 0;
   int rdy_mode = 0;
   bit prio_sel = 1'b0;
   int xsrc = 0;
   int xlen = 0;
   int idx = 0;
   bit prev_stall = 1'b0;
   logic [DW-1:0] prev_data = '0;

   task automatic check(input bit ok, input string tag,
                        input logic [31:0] act, input logic [31:0] expv);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, expv, cyc);
      end
   endtask

   task automatic cycle();
      @(negedge clk);
      cyc++;
      if (cyc > 150000) begin
         n_bad++;
         $display("FAIL R2 watchdog expired actual=%0d expected<150000", cyc);
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
      reg_wr    = pend_wr;
      reg_addr  = pend_addr;
      reg_wdata = pend_data;
      case (cpu_mode)
         1:       cpu_req = (cyc % 2 == 0);
         2:       cpu_req = (cyc % 3 != 0);
         default: cpu_req = 1'b0;
      endcase
      cpu_we    = cyc[2];
      cpu_addr  = AW'(240 + cyc % 16);
      cpu_wdata = DW'(cyc);
      case (rdy_mode)
         1:       dev_ready = cyc[0];
         2:       dev_ready = (cyc % 3 == 0);
         default: dev_ready = 1'b1;
      endcase
      #1;
      if (cpu_gnt)
         check(cpu_req && mem_req && mem_we == cpu_we && mem_addr == cpu_addr,
               "R4 granted CPU drives bus", {mem_we, mem_addr}, {cpu_we, cpu_addr});
      if (cpu_req && prio_sel)
         check(cpu_gnt, "R4 CPU-priority grant", cpu_gnt, 1);
      if (cpu_req && !cpu_gnt)
         check(!prio_sel && mem_req && !mem_we, "R4 CPU loses only to engine",
               {prio_sel, mem_req, mem_we}, 3'b010);
      if (mem_req && !cpu_gnt)
         check(!mem_we && idx < xlen && mem_addr == AW'(xsrc + idx),
               "R3 engine read address", {mem_we, mem_addr}, AW'(xsrc + idx));
      if (prev_stall)
         check(dev_valid && dev_data == prev_data, "R6 stalled word held",
               dev_data, prev_data);
      if (dev_valid && dev_ready) begin
         check(idx < xlen && dev_data == pat(xsrc + idx), "R2 device word",
               dev_data, pat(xsrc + idx));
         idx++;
      end
      prev_stall = dev_valid && !dev_ready;
      prev_data  = dev_data;
   endtask

   task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
      pend_wr = 1'b1; pend_addr = a; pend_data = d;
      cycle();
      pend_wr = 1'b0; pend_addr = 2'd3;
   endtask

   task automatic start_xfer(input int s, input int n, input bit p, input bit ie);
      wr(2'd0, DW'(s));
      wr(2'd1, DW'(n));
      xsrc = s; xlen = n; idx = 0;
      wr(2'd2, DW'({ie, p, 1'b1}));
      prio_sel = p;
      cycle();
      if (n == 0) begin
         check(reg_rdata[1:0] == 2'b10, "R10 zero count sets done only", reg_rdata[1:0], 2'b10);
         check(irq == ie, "R10 zero count irq", irq, ie);
      end else begin
         check(reg_rdata[1:0] == 2'b01, "R2 R11 busy after start, done cleared",
               reg_rdata[1:0], 2'b01);
      end
   endtask

   task automatic clear_done();
      wr(2'd3, DW'(2));
      cycle();
      check(reg_rdata[1:0] == 2'b00 && !irq, "R8 write-1 clears done and irq",
            {irq, reg_rdata[1:0]}, 0);
   endtask

   task automatic wait_done(input bit ie);
      int n = 0;
      while (idx < xlen && n < 400) begin
         cycle();
         n++;
      end
      check(idx == xlen, "R2 all words delivered", idx, xlen);
      cycle();
      check(reg_rdata[1:0] == 2'b10, "R7 done after last word", reg_rdata[1:0], 2'b10);
      check(irq == ie, "R8 irq equals done and enable", irq, ie);
      cycle();
      cycle();
      check(!dev_valid && idx == xlen, "R7 no extra words", idx, xlen);
      wr(2'd3, DW'(0));
      cycle();
      check(reg_rdata[1] == 1'b1, "R8 write-0 keeps done", reg_rdata[1], 1);
      clear_done();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      for (int a = 0; a < 4; a++) begin
         pend_addr = 2'(a);
         cycle();
         check(reg_rdata == '0, "R1 reset register value", reg_rdata, 0);
      end
      check(!irq && !dev_valid && !mem_req, "R1 reset outputs idle",
            {irq, dev_valid, mem_req}, 0);

      wr(2'd0, DW'(16'h5A));
      wr(2'd1, DW'(16'h07));
      wr(2'd2, DW'(6));
      pend_addr = 2'd0; cycle();
      check(reg_rdata == DW'(16'h5A), "R1 source readback", reg_rdata, 16'h5A);
      pend_addr = 2'd1; cycle();
      check(reg_rdata == DW'(16'h07), "R1 count readback", reg_rdata, 16'h07);
      pend_addr = 2'd2; cycle();
      check(reg_rdata == DW'(6), "R1 control readback, start reads 0", reg_rdata, 6);
      pend_addr = 2'd3; cycle();
      check(reg_rdata == '0, "R1 control write without start stays idle", reg_rdata, 0);
      prio_sel = 1'b1;
      wr(2'd2, DW'(0));
      prio_sel = 1'b0;

      for (int n = 0; n < 6; n++)
         for (int p = 0; p < 2; p++)
            for (int rm = 0; rm < 3; rm++)
               for (int cm = 0; cm < 3; cm++) begin
                  cpu_mode = cm;
                  rdy_mode = rm;
                  start_xfer(7 * n + 11 * rm + 3 * cm, n, p[0], 1'((n + rm) % 2));
                  if (n == 0) clear_done();
                  else        wait_done(1'((n + rm) % 2));
               end

      // R9: start and new source while busy
      cpu_mode = 1; rdy_mode = 2;
      start_xfer(40, 6, 1'b0, 1'b1);
      cycle(); cycle(); cycle();
      wr(2'd0, DW'(120));
      wr(2'd2, DW'(5));
      wait_done(1'b1);
      pend_addr = 2'd0; cycle();
      check(reg_rdata == DW'(120), "R9 R1 new source kept for next start", reg_rdata, 120);
      pend_addr = 2'd3;

      // R11: leftover done cleared by a non-zero start
      cpu_mode = 2; rdy_mode = 1;
      start_xfer(60, 0, 1'b0, 1'b0);
      start_xfer(60, 3, 1'b0, 1'b0);
      wait_done(1'b0);

      // long run under CPU priority
      start_xfer(100, 20, 1'b1, 1'b1);
      wait_done(1'b1);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule